// File: doc/BRIEF.md
# Serial Control Register Port

This block is the target side of a three-wire control bus made of a serial clock, one bidirectional data line and an active-low enable. A controller selects the block by pulling the enable low and then shifts a 25-bit frame, most significant bit first. The frame holds a 3-bit device code, a direction bit, a 5-bit register index and 16 data bits. Write frames update a small bank of configuration words that the surrounding logic reads from a flat output bus. Read frames return a live status field or a fixed 32-bit identity split across two registers.

The block runs entirely from a fast system clock that must be at least four times the serial clock rate. All three bus signals pass through synchronizers, and the block acts on the edges it detects. The data line is not a real pad. It is modelled as an input, an output value and an output enable, and the pad buffer sits outside the block.

Top module: `sctl_slave`

## Requirements
- R1: A write frame carries device code, direction bit (0 = write), register index and data in that order, each most significant bit first. When it targets index 4 to 7, the data lands in configuration word index-4, which occupies bits [16*(index-4)+15 : 16*(index-4)] of `cfg_bank_o`.
- R2: A frame is acted on only when its device code is binary 101. Any other code leaves the data enable low for the whole frame and changes no configuration word.
- R3: A complete write takes effect on the first falling serial clock edge after the enable returns high, and not before. That edge may be the first bit clock of the next frame.
- R4: On a read (direction bit 1), the data enable stays low for the 9 header bits. Data is driven from the rising serial clock edge after the header, D15 first, and changes on each rising edge until D0.
- R5: When the enable returns high, the data enable goes low.
- R6: Index 3 reads back the 7-bit status code from `level_i` in bits 6:0, with bits 15:7 equal to zero. All zeros means 0 dBm and all ones means -127 dBm, in 1 dB steps.
- R7: Index 30 reads 0x825D and index 31 reads 0x10B9, the low and high halves of the identity 0x10B9825D.
- R8: A write to any index other than 4 to 7 changes no configuration word. A read of any index other than 3, 30 or 31 returns 0x0000.
- R9: After reset, every configuration word is 0x0000 and the data enable is low.
- R10: If the enable returns high before all 25 bits have been clocked, the frame is dropped and no later clock edge commits it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bus clock from the controller |
| ser_en_n_i | input | 1 | Active-low frame enable |
| ser_dat_i | input | 1 | Data line as seen at the pad |
| ser_dat_o | output | 1 | Value driven onto the data line during reads |
| ser_dat_oe | output | 1 | Drive enable for the data line |
| level_i | input | 7 | Status code returned at index 3 |
| cfg_bank_o | output | 64 | Four configuration words, index 4 in the low word |

## Verification
The commit of a finished write and the first bit of the next frame can land on the same serial clock fall. This happens when the controller lowers the enable again before giving a separate clock pulse. The random sequence leaves about half of its writes uncommitted, so the next frame's opening clock performs the commit. After that frame, the bench checks that the earlier write has landed. It also checks that the new frame was decoded correctly: its read data is right, or its own write is still pending.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   localparam int unsigned SCTL_DEV_W   = 3;
   localparam int unsigned SCTL_ADDR_W  = 5;
   localparam int unsigned SCTL_DATA_W  = 16;
   localparam logic [31:0] SCTL_CHIP_ID = 32'h10B9825D;

   function automatic int unsigned sctl_hdr_bits(input int unsigned dev_w, input int unsigned addr_w);
      return dev_w + 1 + addr_w;
   endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
   parameter int unsigned W       = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sctl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame #(
   parameter int unsigned DEV_W  = 3,
   parameter int unsigned AW     = 5,
   parameter int unsigned DW     = 16,
   parameter logic [DEV_W-1:0] DEV_ID = 3'b101
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_clk,
   input  logic          s_en_n,
   input  logic          s_din,
   input  logic [DW-1:0] rd_data_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          wr_stb_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic          dat_o,
   output logic          dat_oe_o
);
   localparam int unsigned HDR   = sctl_pkg::sctl_hdr_bits(DEV_W, AW);
   localparam int unsigned FRAME = HDR + DW;
   localparam int unsigned CW    = $clog2(FRAME + 2);
   localparam logic [CW-1:0] HDR_C   = CW'(HDR);
   localparam logic [CW-1:0] FRAME_C = CW'(FRAME);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("sctl_frame: DW must be at least 2");
      end
   endgenerate

   logic          clk_q, en_q;
   logic [HDR-1:0] hdr_q;
   logic [DW-1:0] wsh_q, tx_q, wr_data_q;
   logic [AW-1:0] wr_addr_q;
   logic [CW-1:0] cnt_q;
   logic          bit_q, oe_q, pend_q, wr_stb_q;

   wire rise    = s_clk & ~clk_q;
   wire fall    = ~s_clk & clk_q;
   wire en_rise = s_en_n & ~en_q;

   wire [DEV_W-1:0] hdr_dev = hdr_q[HDR-1 -: DEV_W];
   wire             hdr_rw  = hdr_q[AW];
   wire [AW-1:0]    hdr_adr = hdr_q[AW-1:0];
   wire             dev_hit = (hdr_dev == DEV_ID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= 1'b0;
         en_q  <= 1'b1;
      end else begin
         clk_q <= s_clk;
         en_q  <= s_en_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q     <= '0;
         wsh_q     <= '0;
         tx_q      <= '0;
         wr_data_q <= '0;
         wr_addr_q <= '0;
         cnt_q     <= '0;
         bit_q     <= 1'b0;
         oe_q      <= 1'b0;
         pend_q    <= 1'b0;
         wr_stb_q  <= 1'b0;
      end else begin
         wr_stb_q <= 1'b0;
         if (pend_q && fall) begin
            wr_stb_q <= 1'b1;
            pend_q   <= 1'b0;
         end
         if (en_rise) begin
            oe_q  <= 1'b0;
            cnt_q <= '0;
            if (cnt_q == FRAME_C && dev_hit && !hdr_rw) begin
               pend_q    <= 1'b1;
               wr_addr_q <= hdr_adr;
               wr_data_q <= wsh_q;
            end
         end else if (!s_en_n && rise) begin
            if (cnt_q <= FRAME_C) cnt_q <= cnt_q + 1'b1;
            if (cnt_q < HDR_C)        hdr_q <= {hdr_q[HDR-2:0], s_din};
            else if (cnt_q < FRAME_C) wsh_q <= {wsh_q[DW-2:0], s_din};
            if (cnt_q == HDR_C && dev_hit && hdr_rw) begin
               oe_q  <= 1'b1;
               bit_q <= rd_data_i[DW-1];
               tx_q  <= {rd_data_i[DW-2:0], 1'b0};
            end else if (cnt_q > HDR_C && cnt_q < FRAME_C) begin
               bit_q <= tx_q[DW-1];
               tx_q  <= {tx_q[DW-2:0], 1'b0};
            end
         end
      end
   end

   assign rd_addr_o = hdr_adr;
   assign wr_stb_o  = wr_stb_q;
   assign wr_addr_o = wr_addr_q;
   assign wr_data_o = wr_data_q;
   assign dat_o     = bit_q;
   assign dat_oe_o  = oe_q;

   // R4: nothing is driven while the header is still arriving
   a_r4_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (cnt_q > HDR_C));
   // R5: enable rise releases the line
   a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
      en_rise |=> !oe_q);
   // R2: only a read aimed at this device drives
   a_r2_dev_gate: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (dev_hit && hdr_rw));
   // R3: commits only follow a serial clock fall
   a_r3_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb_q |-> $past(fall));
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile #(
   parameter int unsigned AW        = 5,
   parameter int unsigned DW        = 16,
   parameter int unsigned LEVEL_W   = 7,
   parameter int unsigned CFG_BASE  = 4,
   parameter int unsigned CFG_COUNT = 4,
   parameter int unsigned STAT_ADDR = 3,
   parameter int unsigned ID_LO     = 30,
   parameter int unsigned ID_HI     = 31,
   parameter logic [2*DW-1:0] CHIP_ID = sctl_pkg::SCTL_CHIP_ID
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb_i,
   input  logic [AW-1:0]           wr_addr_i,
   input  logic [DW-1:0]           wr_data_i,
   input  logic [AW-1:0]           rd_addr_i,
   input  logic [LEVEL_W-1:0]      level_i,
   output logic [DW-1:0]           rd_data_o,
   output logic [CFG_COUNT*DW-1:0] cfg_bank_o
);
   localparam int unsigned CFG_LAST = CFG_BASE + CFG_COUNT - 1;

   generate
      if (CFG_LAST >= (1 << AW)) begin : g_bad_range
         $error("sctl_regfile: configuration range exceeds address space");
      end
      if (LEVEL_W > DW) begin : g_bad_level
         $error("sctl_regfile: status field wider than data word");
      end
   endgenerate

   wire wr_in_range = (wr_addr_i >= AW'(CFG_BASE)) && (wr_addr_i <= AW'(CFG_LAST));

   generate
      for (genvar i = 0; i < CFG_COUNT; i++) begin : g_cfg
         logic [DW-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        word_q <= '0;
            else if (wr_stb_i && wr_addr_i == AW'(CFG_BASE + i)) word_q <= wr_data_i;
         end
         assign cfg_bank_o[i*DW +: DW] = word_q;

         // R1: a strobe to this index leaves the strobed data in the word
         a_r1_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb_i && wr_addr_i == AW'(CFG_BASE + i)) |=> (word_q == $past(wr_data_i)));
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == AW'(STAT_ADDR))  rd_data_o[LEVEL_W-1:0] = level_i;
      else if (rd_addr_i == AW'(ID_LO)) rd_data_o = CHIP_ID[DW-1:0];
      else if (rd_addr_i == AW'(ID_HI)) rd_data_o = CHIP_ID[2*DW-1:DW];
   end

   // R8: a strobe outside the writable range changes nothing
   a_r8_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb_i && !wr_in_range) |=> $stable(cfg_bank_o));
   // R3 / R10: without a strobe the bank holds
   a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stb_i |=> $stable(cfg_bank_o));
endmodule

// File: rtl/sctl_slave.sv
module sctl_slave #(
   parameter int unsigned DEV_W       = sctl_pkg::SCTL_DEV_W,
   parameter int unsigned AW          = sctl_pkg::SCTL_ADDR_W,
   parameter int unsigned DW          = sctl_pkg::SCTL_DATA_W,
   parameter logic [DEV_W-1:0] DEV_ID = 3'b101,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned LEVEL_W     = 7,
   parameter int unsigned CFG_BASE    = 4,
   parameter int unsigned CFG_COUNT   = 4,
   parameter int unsigned STAT_ADDR   = 3,
   parameter int unsigned ID_LO       = 30,
   parameter int unsigned ID_HI       = 31
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ser_clk_i,
   input  logic                    ser_en_n_i,
   input  logic                    ser_dat_i,
   output logic                    ser_dat_o,
   output logic                    ser_dat_oe,
   input  logic [LEVEL_W-1:0]      level_i,
   output logic [CFG_COUNT*DW-1:0] cfg_bank_o
);
   logic [2:0]    sync_q;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] wr_data;
   logic          wr_stb;

   sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ser_clk_i, ser_en_n_i, ser_dat_i}),
      .q_o   (sync_q)
   );

   sctl_frame #(.DEV_W(DEV_W), .AW(AW), .DW(DW), .DEV_ID(DEV_ID)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_clk     (sync_q[2]),
      .s_en_n    (sync_q[1]),
      .s_din     (sync_q[0]),
      .rd_data_i (rd_data),
      .rd_addr_o (rd_addr),
      .wr_stb_o  (wr_stb),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .dat_o     (ser_dat_o),
      .dat_oe_o  (ser_dat_oe)
   );

   sctl_regfile #(
      .AW(AW), .DW(DW), .LEVEL_W(LEVEL_W), .CFG_BASE(CFG_BASE), .CFG_COUNT(CFG_COUNT),
      .STAT_ADDR(STAT_ADDR), .ID_LO(ID_LO), .ID_HI(ID_HI)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb_i   (wr_stb),
      .wr_addr_i  (wr_addr),
      .wr_data_i  (wr_data),
      .rd_addr_i  (rd_addr),
      .level_i    (level_i),
      .rd_data_o  (rd_data),
      .cfg_bank_o (cfg_bank_o)
   );

   // R9: reset leaves the line undriven
   a_r9_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> !ser_dat_oe);
endmodule

// File: tb/tb_sctl_slave.sv
module tb_sctl_slave;
   localparam int H = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, en_n = 1'b1, din = 1'b0;
   logic [6:0]  level = '0;
   logic        dout, doe;
   logic [63:0] cfg;

   int checks = 0, errors = 0;
   logic [63:0] exp_bank = '0;

   sctl_slave dut (
      .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_en_n_i(en_n), .ser_dat_i(din),
      .ser_dat_o(dout), .ser_dat_oe(doe), .level_i(level), .cfg_bank_o(cfg)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [4:0] a, input logic [6:0] lv);
      if (a == 5'd3)  return {9'd0, lv};
      if (a == 5'd30) return 16'h825D;
      if (a == 5'd31) return 16'h10B9;
      return 16'h0000;
   endfunction

   function automatic logic [63:0] apply_wr(input logic [63:0] b, input logic [2:0] dv,
                                            input logic [4:0] a, input logic [15:0] d);
      logic [63:0] r = b;
      if (dv == 3'b101 && a >= 5'd4 && a <= 5'd7) r[16*(a-4) +: 16] = d;
      return r;
   endfunction

   task automatic frame(input logic [2:0] dv, input logic rw, input logic [4:0] a,
                        input logic [15:0] d, input int nbits,
                        output logic [15:0] rd, output bit hdr_drv, output bit oe_miss);
      logic [24:0] vec = {dv, rw, a, d};
      rd = '0; hdr_drv = 0; oe_miss = 0;
      en_n = 1'b0;
      tick(H);
      for (int i = 0; i < nbits; i++) begin
         din = (rw && i >= 9) ? 1'b0 : vec[24-i];
         tick(H);
         sclk = 1'b1;
         tick(H);
         if (i < 9 && doe) hdr_drv = 1;
         if (i >= 9) begin
            if (!doe) oe_miss = 1;
            rd = {rd[14:0], dout};
         end
         sclk = 1'b0;
      end
      tick(H);
      en_n = 1'b1;
      tick(8);
   endtask

   task automatic pulse();
      sclk = 1'b1;
      tick(H);
      sclk = 1'b0;
      tick(8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      bit hd, om;
      logic [63:0] old;
      void'($urandom(32'd4177));
      tick(5);
      chk("R9 cfg after reset", cfg, 64'd0);
      chk("R9 oe after reset", {63'd0, doe}, 64'd0);
      rst_n = 1'b1;
      tick(5);

      // directed write with explicit commit pulse
      frame(3'b101, 1'b0, 5'd5, 16'hA5C3, 25, rd, hd, om);
      chk("R3 no commit before fall", cfg, 64'd0);
      chk("R5 released after write", {63'd0, doe}, 64'd0);
      pulse();
      exp_bank = apply_wr(exp_bank, 3'b101, 5'd5, 16'hA5C3);
      chk("R1 write index 5", cfg, exp_bank);

      frame(3'b101, 1'b1, 5'd30, 16'h0, 25, rd, hd, om);
      chk("R7 id low", {48'd0, rd}, 64'h825D);
      chk("R4 header quiet", {63'd0, hd}, 64'd0);
      chk("R4 drive through data", {63'd0, om}, 64'd0);
      chk("R5 release after read", {63'd0, doe}, 64'd0);
      frame(3'b101, 1'b1, 5'd31, 16'h0, 25, rd, hd, om);
      chk("R7 id high", {48'd0, rd}, 64'h10B9);

      level = 7'h35;
      frame(3'b101, 1'b1, 5'd3, 16'h0, 25, rd, hd, om);
      chk("R6 status 0x35", {48'd0, rd}, 64'h0035);
      level = 7'h7F;
      frame(3'b101, 1'b1, 5'd3, 16'h0, 25, rd, hd, om);
      chk("R6 status all ones", {48'd0, rd}, 64'h007F);

      frame(3'b101, 1'b0, 5'd30, 16'h1234, 25, rd, hd, om);
      pulse();
      chk("R8 write to id ignored (bank)", cfg, exp_bank);
      frame(3'b101, 1'b1, 5'd30, 16'h0, 25, rd, hd, om);
      chk("R8 id unchanged after write", {48'd0, rd}, 64'h825D);
      frame(3'b101, 1'b1, 5'd5, 16'h0, 25, rd, hd, om);
      chk("R8 write-only reads zero", {48'd0, rd}, 64'h0);

      frame(3'b011, 1'b1, 5'd30, 16'h0, 25, rd, hd, om);
      chk("R2 foreign read not driven", {63'd0, om}, 64'd1);
      chk("R2 foreign header not driven", {63'd0, hd}, 64'd0);
      frame(3'b100, 1'b0, 5'd4, 16'hFFFF, 25, rd, hd, om);
      pulse();
      chk("R2 foreign write ignored", cfg, exp_bank);

      frame(3'b101, 1'b0, 5'd6, 16'hBEEF, 20, rd, hd, om);
      pulse();
      pulse();
      chk("R10 short frame dropped", cfg, exp_bank);

      // random mix; uncommitted writes are committed by the next frame's first fall
      for (int it = 0; it < 70; it++) begin
         logic [2:0] dv;
         logic rw;
         logic [4:0] a;
         logic [15:0] d;
         logic [4:0] pick [7] = '{5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd30, 5'd31};
         dv = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'b101;
         if (($urandom % 4 == 0) && dv == 3'b101) dv = 3'b001;
         rw = 1'($urandom % 2);
         a  = ($urandom % 2 == 0) ? pick[$urandom % 7] : 5'($urandom);
         d  = 16'($urandom);
         level = 7'($urandom);
         old = exp_bank;
         frame(dv, rw, a, d, 25, rd, hd, om);
         chk("R3 bank after frame (pending commit landed, own write held)", cfg, old);
         chk("R5 released", {63'd0, doe}, 64'd0);
         if (rw) begin
            if (dv == 3'b101) begin
               chk("R6 R7 R8 random read data", {48'd0, rd}, {48'd0, exp_rd(a, level)});
               chk("R4 random read drive window", {62'd0, hd, om}, 64'd0);
            end else begin
               chk("R2 random foreign read", {62'd0, hd, om}, 64'd1);
            end
         end else begin
            exp_bank = apply_wr(exp_bank, dv, a, d);
            if ($urandom % 2 == 0) begin
               pulse();
               chk("R1 random write committed", cfg, exp_bank);
            end
         end
      end
      pulse();
      chk("R1 final bank", cfg, exp_bank);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule